// File: doc/BRIEF.md
# DRAM Read Burst Data Sequencer

This block models the read data path of a double-data-rate graphics DRAM as seen from the device side. Decoded READ commands come in with a bank, a starting column and an auto-precharge flag. After a selectable CAS latency, the block plays out a burst of data elements, two per clock cycle: one for the rising half and one for the falling half. Alongside the data it drives a read strobe that is edge-aligned to the clock. The strobe starts with a one-cycle preamble and ends with a low postamble half. While the strobe is driven, it turns off the on-die termination enable.

Each cycle is presented as a pair of half-cycle values (`*_r` for the high clock phase, `*_f` for the low phase), so a downstream double-rate output stage can serialise them. When `dq_oe` is low the data bus counts as released (high impedance) and both data lanes read as zero. The array content comes from a small generator: the value of cell (bank, column) is `{bank, column}` zero-extended to the data width and XORed with the `SEED` parameter. A READ that arrives exactly one burst duration after the previous accepted one continues the data stream with no gap. A READ that arrives sooner is dropped, so a running burst always completes.

Top module: `rdseq_top`

## Requirements
- R1: While reset is held, `dq_oe`, `dqs_oe`, `dqs_r`, `dqs_f` and `pre_fire` are 0, both data lanes are 0 and `odt_en` is 1.
- R2: A READ sampled on clock edge n with effective latency L makes `dq_oe` high from edge n+L for exactly BURST_LEN/2 cycles.
- R3: In burst cycle k (k = 0 .. BURST_LEN/2-1), `dq_r` carries element 2k and `dq_f` carries element 2k+1. Element i reads column (start & ~(BURST_LEN-1)) | ((start + i) mod BURST_LEN) of the commanded bank, with value ({bank, column} zero-extended) XOR SEED.
- R4: When no data was driven in the previous cycle, `dqs_oe` rises one cycle before `dq_oe` (the preamble). Whenever `dqs_oe` is high, `dqs_r` is 1 and `dqs_f` is 0, so the last data element sits in a low strobe half (the postamble). `dqs_f` is always 0.
- R5: In any cycle without data, `dq_oe` is 0 and both data lanes are 0. After a burst with no follow-on READ, `dqs_oe` also drops in the following cycle.
- R6: A READ accepted exactly BURST_LEN/2 cycles after the previous one produces its first pair in the cycle right after the previous burst's last pair, and `dq_oe` stays high throughout.
- R7: A READ sampled fewer than BURST_LEN/2 cycles after the last accepted READ is dropped. The running burst finishes unchanged and no extra data appears.
- R8: `odt_en` is 0 in every cycle where `dqs_oe` is 1, and 1 otherwise.
- R9: `pre_fire` is 1, with `pre_bank` equal to the burst's bank, in exactly the cycle that carries the last pair of a burst whose auto-precharge flag was set. In every other cycle it is 0.
- R10: A `cas_lat` below CL_MIN acts as CL_MIN and one above CL_MAX acts as CL_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | READ command strobe, sampled each rising edge |
| rd_bank | input | $clog2(BANKS) | Bank of the READ |
| rd_col | input | $clog2(COLS) | Starting column of the READ |
| rd_ap | input | 1 | Auto-precharge flag of the READ |
| cas_lat | input | $clog2(CL_MAX+1) | CAS latency in cycles; hold it constant while reads are in flight |
| dq_r | output | DW | Data element for the high clock phase |
| dq_f | output | DW | Data element for the low clock phase |
| dq_oe | output | 1 | Data driven (data valid); low means the bus is released |
| dqs_r | output | 1 | Strobe level in the high clock phase |
| dqs_f | output | 1 | Strobe level in the low clock phase |
| dqs_oe | output | 1 | Strobe driven (strobe enable) |
| odt_en | output | 1 | On-die termination enable |
| pre_fire | output | 1 | Auto-precharge request at the end of a burst |
| pre_bank | output | $clog2(BANKS) | Bank named by `pre_fire` |

## Verification
The checker watches the invariants that hold in every cycle. Data is never driven without the strobe. Termination is off whenever the strobe is on. Idle data lanes are zero. Each new data run is preceded by a preamble cycle. Every run of `dq_oe` is a whole number of bursts. A precharge request only appears inside a burst. The exact latency per CAS setting, the wrapped column order and cell values, seamless chaining, the dropping of early READs and the clamping of latency can only be shown by the bench. It sweeps all latencies and several start columns and compares every output, every cycle, with a schedule it computes itself.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  // Data elements carried per clock cycle (one per clock phase).
  localparam int PHASES = 2;

  // Bit width of a counter or index that must hold values 0 .. n-1.
  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rdseq_gate.sv
// Admits a READ only when a full burst duration has passed since the last
// admitted one, so a burst already scheduled is never cut short.
module rdseq_gate #(
  parameter int SPACING = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic take
);
  import rdseq_pkg::*;

  localparam int GW = width_of(SPACING);
  localparam logic [GW-1:0] READY = GW'(SPACING - 1);

  logic [GW-1:0] gap_q, gap_n;

  always_comb begin
    take  = req && (gap_q == READY);
    gap_n = gap_q;
    if (take)
      gap_n = '0;
    else if (gap_q != READY)
      gap_n = gap_q + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_q <= READY;
    else
      gap_q <= gap_n;
  end

endmodule

// File: rtl/rdseq_latline.sv
// Delay line for admitted commands. The start tap fires one cycle before the
// first data pair is registered; the preamble tap fires one cycle earlier.
module rdseq_latline #(
  parameter int DEPTH = 9,
  parameter int W     = 7,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [W-1:0]  in_d,
  input  logic [LW-1:0] lat,
  output logic          start_v,
  output logic [W-1:0]  start_d,
  output logic          pre_v
);

  logic          v_q [DEPTH];
  logic [W-1:0]  d_q [DEPTH];
  logic [LW-1:0] tap_s, tap_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      v_q[0] <= 1'b0;
    else
      v_q[0] <= in_v;
  end

  always_ff @(posedge clk) begin
    if (in_v)
      d_q[0] <= in_d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        v_q[i] <= 1'b0;
      else
        v_q[i] <= v_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (v_q[i-1])
        d_q[i] <= d_q[i-1];
    end
  end

  always_comb begin
    tap_s   = lat - LW'(1);
    tap_p   = lat - LW'(2);
    start_v = v_q[tap_s];
    start_d = d_q[tap_s];
    pre_v   = v_q[tap_p];
  end

endmodule

// File: rtl/rdseq_burst.sv
// Burst engine: beat counter, wrapped column sequence, data pair, strobe,
// termination control and end-of-burst precharge request.
module rdseq_burst #(
  parameter int          DW        = 8,
  parameter int          BW        = 2,
  parameter int          CW        = 4,
  parameter int          BURST_LEN = 8,
  parameter logic [DW-1:0] SEED    = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] s_bank,
  input  logic [CW-1:0] s_col,
  input  logic          s_ap,
  input  logic          pre_soon,
  output logic [DW-1:0] dq_r,
  output logic [DW-1:0] dq_f,
  output logic          dq_oe,
  output logic          dqs_r,
  output logic          dqs_f,
  output logic          dqs_oe,
  output logic          odt_en,
  output logic          pre_fire,
  output logic [BW-1:0] pre_bank
);
  import rdseq_pkg::*;

  localparam int LB  = $clog2(BURST_LEN);
  localparam int BLC = BURST_LEN / PHASES;
  localparam int BTW = width_of(BLC);
  localparam logic [BTW-1:0] LAST_BEAT = BTW'(BLC - 1);

  logic           act_q, act_n;
  logic [BTW-1:0] beat_q, beat_n;
  logic [BW-1:0]  bank_q, bank_n;
  logic [CW-1:0]  col_q, col_n;
  logic           ap_q, ap_n;
  logic           last;
  logic [DW-1:0]  val_n [PHASES];
  logic [CW-1:0]  ecol  [PHASES];
  logic [DW-1:0]  dqr_q, dqf_q;
  logic           soe_q, soe_n;
  logic           odt_q, odt_n;

  // Next state of the beat sequencer.
  always_comb begin
    last   = act_q && (beat_q == LAST_BEAT);
    act_n  = act_q;
    beat_n = beat_q;
    bank_n = bank_q;
    col_n  = col_q;
    ap_n   = ap_q;
    if (start) begin
      act_n  = 1'b1;
      beat_n = '0;
      bank_n = s_bank;
      col_n  = s_col;
      ap_n   = s_ap;
    end else if (last) begin
      act_n  = 1'b0;
      beat_n = '0;
    end else if (act_q) begin
      beat_n = beat_q + BTW'(1);
    end
    soe_n = act_n || pre_soon;
    odt_n = !(act_n || pre_soon);
  end

  // One column and cell value per clock phase, wrapped inside the burst block.
  for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
    assign ecol[ph]  = {col_n[CW-1:LB],
                        col_n[LB-1:0] + LB'(PHASES * int'(beat_n) + ph)};
    assign val_n[ph] = act_n ? (DW'({bank_n, ecol[ph]}) ^ SEED) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      ap_q   <= 1'b0;
      dqr_q  <= '0;
      dqf_q  <= '0;
      soe_q  <= 1'b0;
      odt_q  <= 1'b1;
    end else begin
      act_q  <= act_n;
      beat_q <= beat_n;
      ap_q   <= ap_n;
      dqr_q  <= val_n[0];
      dqf_q  <= val_n[1];
      soe_q  <= soe_n;
      odt_q  <= odt_n;
    end
  end

  // Address fields carry no reset; they only load with a burst start.
  always_ff @(posedge clk) begin
    if (start) begin
      bank_q <= bank_n;
      col_q  <= col_n;
    end
  end

  assign dq_r     = dqr_q;
  assign dq_f     = dqf_q;
  assign dq_oe    = act_q;
  assign dqs_oe   = soe_q;
  assign dqs_r    = soe_q;
  assign dqs_f    = 1'b0;
  assign odt_en   = odt_q;
  assign pre_fire = last && ap_q;
  assign pre_bank = bank_q;

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top #(
  parameter int            DW        = 8,
  parameter int            BANKS     = 4,
  parameter int            COLS      = 16,
  parameter int            BURST_LEN = 8,
  parameter int            CL_MIN    = 5,
  parameter int            CL_MAX    = 9,
  parameter logic [DW-1:0] SEED      = 8'hA5,
  localparam int           BW        = $clog2(BANKS),
  localparam int           CW        = $clog2(COLS),
  localparam int           LW        = $clog2(CL_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [BW-1:0] rd_bank,
  input  logic [CW-1:0] rd_col,
  input  logic          rd_ap,
  input  logic [LW-1:0] cas_lat,
  output logic [DW-1:0] dq_r,
  output logic [DW-1:0] dq_f,
  output logic          dq_oe,
  output logic          dqs_r,
  output logic          dqs_f,
  output logic          dqs_oe,
  output logic          odt_en,
  output logic          pre_fire,
  output logic [BW-1:0] pre_bank
);
  import rdseq_pkg::*;

  localparam int PW  = BW + CW + 1;
  localparam int BLC = BURST_LEN / PHASES;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          take;
  logic [LW-1:0] lat_eff;
  logic          st_v, pre_v;
  logic [PW-1:0] st_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    if (cas_lat < LW'(CL_MIN))
      lat_eff = LW'(CL_MIN);
    else if (cas_lat > LW'(CL_MAX))
      lat_eff = LW'(CL_MAX);
    else
      lat_eff = cas_lat;
  end

  rdseq_gate #(.SPACING(BLC)) u_gate (
    .clk   (clk),
    .rst_n (rst_int_n),
    .req   (rd_req),
    .take  (take)
  );

  rdseq_latline #(.DEPTH(CL_MAX), .W(PW), .LW(LW)) u_lat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .in_v    (take),
    .in_d    ({rd_bank, rd_col, rd_ap}),
    .lat     (lat_eff),
    .start_v (st_v),
    .start_d (st_d),
    .pre_v   (pre_v)
  );

  rdseq_burst #(
    .DW(DW), .BW(BW), .CW(CW), .BURST_LEN(BURST_LEN), .SEED(SEED)
  ) u_burst (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (st_v),
    .s_bank   (st_d[PW-1 -: BW]),
    .s_col    (st_d[CW:1]),
    .s_ap     (st_d[0]),
    .pre_soon (pre_v),
    .dq_r     (dq_r),
    .dq_f     (dq_f),
    .dq_oe    (dq_oe),
    .dqs_r    (dqs_r),
    .dqs_f    (dqs_f),
    .dqs_oe   (dqs_oe),
    .odt_en   (odt_en),
    .pre_fire (pre_fire),
    .pre_bank (pre_bank)
  );

endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk #(
  parameter int DW        = 8,
  parameter int BURST_LEN = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] dq_r,
  input logic [DW-1:0] dq_f,
  input logic          dq_oe,
  input logic          dqs_oe,
  input logic          odt_en,
  input logic          pre_fire
);
  localparam int BLC = BURST_LEN / 2;

  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (dq_oe)
      run_q <= run_q + 16'd1;
    else
      run_q <= '0;
  end

  AST_DATA_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);                                            // R4
  AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe));                              // R4
  AST_ODT_OFF_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_oe |-> !odt_en);                                          // R8
  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_r == '0 && dq_f == '0));                       // R5
  AST_WHOLE_BURSTS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (run_q != 16'd0 && (run_q % BLC) == 0));     // R7
  AST_PRECHARGE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |-> dq_oe);                                          // R9

endmodule

bind rdseq_top rdseq_chk #(.DW(DW), .BURST_LEN(BURST_LEN)) u_chk (.*);

// File: tb/tb_rdseq_top.sv
`timescale 1ns/1ps
module tb_rdseq_top;
  localparam int BL    = 8;
  localparam int BLC   = BL / 2;
  localparam int CLMIN = 5;
  localparam int CLMAX = 9;
  localparam int RING  = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_req;
  logic [1:0] rd_bank;
  logic [3:0] rd_col;
  logic       rd_ap;
  logic [3:0] cas_lat;
  logic [7:0] dq_r, dq_f;
  logic       dq_oe, dqs_r, dqs_f, dqs_oe, odt_en, pre_fire;
  logic [1:0] pre_bank;

  rdseq_top dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_bank(rd_bank),
    .rd_col(rd_col), .rd_ap(rd_ap), .cas_lat(cas_lat),
    .dq_r(dq_r), .dq_f(dq_f), .dq_oe(dq_oe), .dqs_r(dqs_r), .dqs_f(dqs_f),
    .dqs_oe(dqs_oe), .odt_en(odt_en), .pre_fire(pre_fire), .pre_bank(pre_bank)
  );

  always #10 clk = ~clk;

  int    checks = 0, errors = 0, cyc = 0, last_acc = 0;
  bit    any_acc = 0, mon_on = 0, done = 0;
  string scen = "R2";
  int    e_oe [RING], e_r [RING], e_f [RING], e_dqs [RING], e_pre [RING], e_pb [RING];

  function automatic int cellv(int b, int c);
    return ((b * 16 + c) ^ 'hA5) & 'hFF;
  endfunction
  function automatic int colat(int c, int i);
    return (c - (c % BL)) + ((c + i) % BL);
  endfunction
  function automatic int leff(int l);
    return (l < CLMIN) ? CLMIN : (l > CLMAX) ? CLMAX : l;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) cycle %0d %s: actual %0d expected %0d",
               req, scen, cyc, what, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Compare every output with the bench schedule, every cycle.
  always @(negedge clk) begin
    if (mon_on) begin
      automatic int s = cyc % RING;
      check(scen, "dq_oe", int'(dq_oe), e_oe[s]);
      check(e_oe[s] != 0 ? "R3" : "R5", "dq_r", int'(dq_r), e_r[s]);
      check(e_oe[s] != 0 ? "R3" : "R5", "dq_f", int'(dq_f), e_f[s]);
      check("R4", "dqs_oe", int'(dqs_oe), e_dqs[s]);
      check("R4", "dqs_r", int'(dqs_r), e_dqs[s]);
      check("R4", "dqs_f", int'(dqs_f), 0);
      check("R8", "odt_en", int'(odt_en), e_dqs[s] != 0 ? 0 : 1);
      check("R9", "pre_fire", int'(pre_fire), e_pre[s]);
      if (e_pre[s] != 0) check("R9", "pre_bank", int'(pre_bank), e_pb[s]);
      e_oe[s] = 0; e_r[s] = 0; e_f[s] = 0; e_dqs[s] = 0; e_pre[s] = 0; e_pb[s] = 0;
    end
  end

  // One cycle of command input; the bench model decides admission (R7).
  task automatic cmd(bit v, int b, int c, bit ap);
    @(negedge clk);
    rd_req = v; rd_bank = 2'(b); rd_col = 4'(c); rd_ap = ap;
    if (v && (!any_acc || (cyc + 1 - last_acc) >= BLC)) begin
      automatic int n = cyc + 1;
      automatic int l = leff(int'(cas_lat));
      last_acc = n; any_acc = 1;
      e_dqs[(n + l - 1) % RING] = 1;
      for (int i = 0; i < BLC; i++) begin
        automatic int s = (n + l + i) % RING;
        e_oe[s] = 1; e_dqs[s] = 1;
        e_r[s] = cellv(b, colat(c, 2 * i));
        e_f[s] = cellv(b, colat(c, 2 * i + 1));
        e_pre[s] = (i == BLC - 1 && ap) ? 1 : 0;
        e_pb[s] = b;
      end
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cmd(0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < RING; i++) begin
      e_oe[i] = 0; e_r[i] = 0; e_f[i] = 0; e_dqs[i] = 0; e_pre[i] = 0; e_pb[i] = 0;
    end
    rst_n = 1'b0; rd_req = 0; rd_bank = 0; rd_col = 0; rd_ap = 0; cas_lat = 4'd5;
    repeat (3) @(negedge clk);
    scen = "R1";
    check("R1", "dq_oe", int'(dq_oe), 0);
    check("R1", "dqs_oe", int'(dqs_oe), 0);
    check("R1", "dqs_r", int'(dqs_r), 0);
    check("R1", "odt_en", int'(odt_en), 1);
    check("R1", "pre_fire", int'(pre_fire), 0);
    check("R1", "dq_r", int'(dq_r), 0);
    check("R1", "dq_f", int'(dq_f), 0);
    rst_n = 1'b1;
    mon_on = 1;
    scen = "R2";
    idle(4);

    // Sweep of every latency against several start columns.
    for (int l = CLMIN; l <= CLMAX; l++) begin
      cas_lat = 4'(l);
      for (int j = 0; j < 4; j++) begin
        automatic int cl[4] = '{0, 3, 6, 13};
        cmd(1, j, cl[j], j[0]);
        idle(l + BLC + 2);
      end
    end

    // R6: three chained reads, exactly one burst duration apart.
    scen = "R6"; cas_lat = 4'd6;
    cmd(1, 1, 2, 0); idle(BLC - 1);
    cmd(1, 2, 15, 0); idle(BLC - 1);
    cmd(1, 3, 8, 1); idle(6 + BLC + 2);

    // One-cycle gap between bursts: strobe bridges the gap as preamble.
    scen = "R2"; cas_lat = 4'd7;
    cmd(1, 0, 9, 1); idle(BLC);
    cmd(1, 1, 4, 1); idle(7 + BLC + 2);

    // R7: early reads are dropped, the running burst completes.
    scen = "R7"; cas_lat = 4'd8;
    cmd(1, 1, 5, 1);
    cmd(1, 2, 9, 0);
    idle(1);
    cmd(1, 3, 2, 1);
    cmd(1, 0, 4, 0);
    idle(8 + 2 * BLC + 2);

    // R10: latency clamping at both ends.
    scen = "R10";
    cas_lat = 4'd2;  cmd(1, 2, 11, 1); idle(CLMAX + BLC + 2);
    cas_lat = 4'd15; cmd(1, 3, 7, 0);  idle(CLMAX + BLC + 2);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule